// File: doc/BRIEF.md
# Burst-of-Two Pipelined SRAM Core

A small synchronous memory with one shared address bus, a write-data bus and a read-data bus. Every access moves two words. The first word is at the supplied address. The second is at the same address with bit 0 inverted, so a burst always stays inside its aligned pair. The core runs on a single clock. A beat-index output splits each access period into two beats. Read requests are taken on beat 0 and write requests on beat 1, so the two kinds of request can share the address bus within one period.

Write data follows the write request. The first word is sampled on the next beat and the second word on the beat after that. Both words are then committed to the array together.

Read data comes back through a short pipeline. A read-valid flag marks each beat on which the data output is driven. The host uses this flag as the output enable. A read that comes straight after a write to the same pair returns the new write data, even though that data reaches the array only during the read's own pipeline.

Top module: `burst2_sram`

## Requirements
- R1: While reset is asserted and on the first beat after it, `q_valid_o` is 0 and `beat_o` is 0.
- R2: `beat_o` alternates 0,1,0,1 after reset. `rd_n_i` is sampled only on beat-0 edges and `wr_n_i` only on beat-1 edges. A strobe held low on the other beat changes neither the outputs nor the stored data.
- R3: A write request samples `addr_i` = W on its beat-1 edge. The next `d_i` sample (beat 0) is stored at W and the one after it (beat 1) is stored at W with bit 0 inverted.
- R4: The second word of any burst uses the address with bit 0 inverted. For an odd start address this is the lower address of the pair.
- R5: A read sampled on beat-0 edge E drives the word at address A on `q_o` during the beat after edge E+2. It drives the word at A with bit 0 inverted during the beat after E+3. `q_valid_o` is 1 on both of these beats.
- R6: If no read was sampled at edge E, `q_valid_o` is 0 during the two beats that such a read would have used.
- R7: A read sampled one beat after a write request whose pair address matches returns that write's data, not the older contents.
- R8: A write requested on the beat right after a read (same period) is not visible to that read.
- R9: Reads issued in consecutive periods keep `q_valid_o` high without a gap.
- R10: `q_o` is all zeros whenever `q_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Beat clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_n_i | input | 1 | Active-low read request, sampled on beat 0 |
| wr_n_i | input | 1 | Active-low write request, sampled on beat 1 |
| addr_i | input | AW | Shared address bus |
| d_i | input | DW | Write data, one word per beat |
| beat_o | output | 1 | Current beat index within the period |
| q_o | output | DW | Read data, zero when not driven |
| q_valid_o | output | 1 | Read data valid / output enable |

## Verification
The array is first filled with aligned pair writes. After that, random mixes of reads, writes and idle periods are compared word by word against a reference memory updated in request order.

Directed periods cover the orderings that random traffic rarely hits:
- A read one beat after a write to the same pair, which tells forwarding apart from a stale array read.
- A read and a write in the same period, which tells "write after read" apart from a premature forward.
- Odd-address bursts, which separate wrap-in-pair from a plain increment.
- Strobes on the wrong beat, which must leave the data visible on later reads unchanged.

Runs of back-to-back reads and idle periods check the valid flag's continuity and its drop to zero.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  typedef enum logic {BEAT_RD = 1'b0, BEAT_WR = 1'b1} beat_e;
endpackage

// File: rtl/burst2_pair_mem.sv
module burst2_pair_mem #(
  parameter int PW = 5,
  parameter int WW = 36
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [WW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [PW-1:0] raddr_i,
  output logic [WW-1:0] rdata_o
);
  localparam int Depth = 1 << PW;

  logic [WW-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write on a shared edge
  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/burst2_wr_path.sv
module burst2_wr_path
  import burst2_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  beat_e           beat_i,
  input  logic            wr_n_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   d_i,
  output logic            commit_o,
  output logic [AW-2:0]   commit_pair_o,
  output logic [2*DW-1:0] commit_data_o
);
  logic          req_q, pend_q;
  logic [AW-1:0] wa_q;
  logic [DW-1:0] d0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      wa_q   <= '0;
      d0_q   <= '0;
    end else if (beat_i == BEAT_WR) begin
      req_q <= !wr_n_i;
      if (!wr_n_i) wa_q <= addr_i;
    end else begin
      pend_q <= req_q;
      d0_q   <= d_i;
    end
  end

  // second word arrives on the commit edge itself
  assign commit_o      = (beat_i == BEAT_WR) && pend_q;
  assign commit_pair_o = wa_q[AW-1:1];

  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign commit_data_o[s*DW +: DW] = (wa_q[0] == 1'(s)) ? d0_q : d_i;
  end
endmodule

// File: rtl/burst2_rd_path.sv
module burst2_rd_path
  import burst2_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  beat_e           beat_i,
  input  logic            rd_n_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [2*DW-1:0] mem_rdata_i,
  input  logic            commit_i,
  input  logic [AW-2:0]   commit_pair_i,
  input  logic [2*DW-1:0] commit_data_i,
  output logic            re_o,
  output logic [AW-2:0]   raddr_o,
  output logic [DW-1:0]   q_o,
  output logic            q_valid_o
);
  logic            v1_q, v2_q;
  logic [AW-1:0]   ra1_q, ra2_q;
  logic [2*DW-1:0] pair_q;
  logic            hit;
  logic            sel;
  logic [DW-1:0]   word;

  assign re_o    = (beat_i == BEAT_RD) && !rd_n_i;
  assign raddr_o = addr_i[AW-1:1];

  // the write committing on this edge is the one the array read missed
  assign hit  = commit_i && (commit_pair_i == ra1_q[AW-1:1]);
  assign sel  = ra2_q[0] ^ beat_i;
  assign word = sel ? pair_q[DW +: DW] : pair_q[0 +: DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      ra1_q  <= '0;
      ra2_q  <= '0;
      pair_q <= '0;
    end else if (beat_i == BEAT_RD) begin
      v1_q <= re_o;
      if (re_o) ra1_q <= addr_i;
    end else begin
      v2_q  <= v1_q;
      ra2_q <= ra1_q;
      if (v1_q) pair_q <= hit ? commit_data_i : mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o       <= '0;
      q_valid_o <= 1'b0;
    end else begin
      q_o       <= v2_q ? word : '0;
      q_valid_o <= v2_q;
    end
  end
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
  import burst2_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] d_i,
  output logic          beat_o,
  output logic [DW-1:0] q_o,
  output logic          q_valid_o
);
  localparam int PW = AW - 1;
  localparam int WW = 2 * DW;

  beat_e         beat_q;
  logic          commit;
  logic [PW-1:0] commit_pair;
  logic [WW-1:0] commit_data;
  logic          re;
  logic [PW-1:0] raddr;
  logic [WW-1:0] rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= BEAT_RD;
    else         beat_q <= (beat_q == BEAT_RD) ? BEAT_WR : BEAT_RD;
  end
  assign beat_o = beat_q;

  burst2_wr_path #(.AW(AW), .DW(DW)) u_wr (
    .clk_i, .rst_ni, .beat_i(beat_q), .wr_n_i, .addr_i, .d_i,
    .commit_o(commit), .commit_pair_o(commit_pair), .commit_data_o(commit_data)
  );

  burst2_pair_mem #(.PW(PW), .WW(WW)) u_mem (
    .clk_i, .we_i(commit), .waddr_i(commit_pair), .wdata_i(commit_data),
    .re_i(re), .raddr_i(raddr), .rdata_o(rdata)
  );

  burst2_rd_path #(.AW(AW), .DW(DW)) u_rd (
    .clk_i, .rst_ni, .beat_i(beat_q), .rd_n_i, .addr_i,
    .mem_rdata_i(rdata), .commit_i(commit), .commit_pair_i(commit_pair),
    .commit_data_i(commit_data), .re_o(re), .raddr_o(raddr),
    .q_o, .q_valid_o
  );
endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_n_i,
  input logic beat_o,
  input logic q_valid_o
);
  AST_RISE_ON_WORD0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_valid_o) |-> beat_o == 1'b1); // R5

  AST_FALL_AFTER_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(q_valid_o) |-> beat_o == 1'b1); // R9

  AST_VALID_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_valid_o) |-> ($past(rd_n_i, 3) == 1'b0 && $past(beat_o, 3) == 1'b0)); // R5

  AST_NOP_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o == 1'b1 && $past(rd_n_i, 3) == 1'b1) |-> !q_valid_o); // R6
endmodule

bind burst2_sram burst2_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_n_i(rd_n_i),
  .beat_o(beat_o), .q_valid_o(q_valid_o)
);

// File: tb/burst2_sram_test.sv
`timescale 1ns/1ps
module burst2_sram_test;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic beat, q_valid;
  logic [DW-1:0] q;

  always #2.5 clk = ~clk;

  burst2_sram #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .addr_i(addr), .d_i(d), .beat_o(beat), .q_o(q), .q_valid_o(q_valid)
  );

  int checks = 0, fails = 0, beat_no = 0;
  logic [DW-1:0] ref_mem [int];
  bit            exp_v   [int];
  logic [DW-1:0] exp_d   [int];
  string         exp_t   [int];
  bit            pw = 1'b0;
  logic [AW-1:0] pwa = '0;
  logic [DW-1:0] pd0 = '0, pd1 = '0;
  int unsigned   seed_dummy;

  function automatic logic [AW-1:0] partner(logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  function automatic logic [DW-1:0] model_rd(logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s beat=%0d actual=%0h expected=%0h", tag, what, beat_no, act, exp);
    end
  endtask

  task automatic look();
    if (exp_v.exists(beat_no))
      chk(q_valid === 1'b1 && q === exp_d[beat_no], exp_t[beat_no], "read word",
          {13'd0, q_valid, q}, {13'd0, 1'b1, exp_d[beat_no]});
    else
      chk(q_valid === 1'b0 && q === '0, "R6/R10", "idle output",
          {13'd0, q_valid, q}, 32'd0);
    chk(beat === beat_no[0], "R2", "beat index", {31'd0, beat}, {31'd0, beat_no[0]});
  endtask

  task automatic period(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                        logic [DW-1:0] w0, logic [DW-1:0] w1, string tag,
                        bit rd_bad = 1'b0, bit wr_bad = 1'b0);
    if (pw) begin
      ref_mem[int'(pwa)] = pd0;
      ref_mem[int'(partner(pwa))] = pd1;
    end
    if (rd) begin
      exp_v[beat_no + 3] = 1'b1; exp_d[beat_no + 3] = model_rd(ra);          exp_t[beat_no + 3] = tag;
      exp_v[beat_no + 4] = 1'b1; exp_d[beat_no + 4] = model_rd(partner(ra)); exp_t[beat_no + 4] = tag;
    end
    look();
    rd_n = !rd; wr_n = !wr_bad; addr = ra; d = pw ? pd0 : DW'($urandom);
    @(posedge clk); beat_no++; @(negedge clk);
    look();
    rd_n = !rd_bad; wr_n = !wr; addr = wa; d = pw ? pd1 : DW'($urandom);
    @(posedge clk); beat_no++; @(negedge clk);
    pw = wr; pwa = wa; pd0 = w0; pd1 = w1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) period(1'b0, '0, 1'b0, '0, '0, '0, "R6");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    seed_dummy = $urandom(32'h5eed_b2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q_valid === 1'b0 && beat === 1'b0, "R1", "in reset", {30'd0, q_valid, beat}, 32'd0);
    rst_n = 1'b1;
    chk(q_valid === 1'b0 && beat === 1'b0, "R1", "after reset", {30'd0, q_valid, beat}, 32'd0);

    // fill every aligned pair
    for (int k = 0; k < (1 << (AW - 1)); k++)
      period(1'b0, '0, 1'b1, AW'(2 * k), DW'($urandom), DW'($urandom), "R3");
    idle(1);

    // R3: readback of the fill, even and odd start
    for (int k = 0; k < 8; k++) period(1'b1, AW'(k * 3), 1'b0, '0, '0, '0, "R3");
    idle(2);

    // R4: odd start address wraps to the lower word of the pair
    period(1'b0, '0, 1'b1, 6'd7, 18'h1aaaa, 18'h05555, "R4");
    idle(1);
    period(1'b1, 6'd6, 1'b0, '0, '0, '0, "R4");
    period(1'b1, 6'd7, 1'b0, '0, '0, '0, "R3");
    idle(2);

    // R7: read one beat after a write to the same pair
    period(1'b0, '0, 1'b1, 6'd10, 18'h0abcd, 18'h3dcba, "R7");
    period(1'b1, 6'd10, 1'b0, '0, '0, '0, "R7");
    period(1'b0, '0, 1'b1, 6'd12, 18'h01111, 18'h02222, "R7");
    period(1'b1, 6'd13, 1'b0, '0, '0, '0, "R7");
    idle(2);

    // R8: read and write in the same period, then read again
    period(1'b1, 6'd20, 1'b1, 6'd20, 18'h33333, 18'h04444, "R8");
    period(1'b1, 6'd20, 1'b0, '0, '0, '0, "R7");
    idle(2);

    // R2: strobes on the wrong beat are ignored
    period(1'b0, 6'd30, 1'b0, 6'd30, '0, '0, "R2", 1'b1, 1'b1);
    period(1'b0, 6'd30, 1'b0, 6'd30, '0, '0, "R2", 1'b1, 1'b1);
    idle(1);
    period(1'b1, 6'd30, 1'b0, '0, '0, '0, "R2");
    idle(2);

    // R9: back-to-back reads
    for (int k = 0; k < 6; k++) period(1'b1, AW'(40 + k), 1'b0, '0, '0, '0, "R9");
    idle(3);

    // R5: random mix against the reference
    for (int k = 0; k < 400; k++)
      period(($urandom % 10) < 6, AW'($urandom), ($urandom % 10) < 5, AW'($urandom),
             DW'($urandom), DW'($urandom), "R5");
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule